// File: doc/BRIEF.md
# Lane-Masked Single-Port RAM

This block is a single-port synchronous memory whose writes can be limited to chosen lanes of the data word. One enable bit is assigned to each lane. When a write is requested, only the lanes whose enable bit is set take the new data. Every other lane keeps the value it already held. The lane size depends on the word width. Words of 16 or 32 bits are divided into 8-bit lanes. Words of 18 or 36 bits are divided into 9-bit lanes, so the extra bit of each group stays with its group.

Every access passes through two register stages. On the first rising edge with the clock enable high, the address, write data, write enable and lane enables are captured. On the next such edge, the memory is written and read at that captured address. The read value is placed on a registered output. When a write and a read hit the same address in one access, the read returns the old contents.

Byte masking is selected at build time. When it is turned off, the word is a single lane, the enable vector is held at all ones, and writes depend only on the write enable. Asking for masking with a word narrower than 16 bits stops elaboration, and so does asking for it with any width other than 16, 18, 32 or 36. The ports carry no valid/ready handshake and nothing can apply back-pressure. The clock enable is the only way to stall, and it freezes both stages.

Top module: `byte_lane_ram`

## Requirements
- R1: With the captured write enable low, an access leaves the stored word unchanged, whatever the lane enables and data hold.
- R2: With byte masking on and 36-bit words, enable bit k covers data bits [9k+8:9k]. The lane is 9 bits for 18/36-bit words and 8 bits for 16/32-bit words.
- R3: In a write, a lane whose enable bit is 0 keeps its previous contents. Every enable combination is legal, including all zeros, which leaves the word unchanged.
- R4: With 16-bit words, enable bit 0 covers data bits [7:0] and enable bit 1 covers bits [15:8].
- R5: Inputs are captured only on rising edges where `ce_i` is 1. While `ce_i` is 0, nothing is written, `rd_data_o` holds, and the capture registers hold.
- R6: A request captured on one enabled edge has its read result on `rd_data_o` after the next enabled edge. A read that directly follows a write to the same address returns the new data.
- R7: An access that writes and reads the same address returns the contents from before the write.
- R8: With byte masking off, `be_i` has no effect: a write with `we_i` high replaces the whole word.
- R9: While `rst_ni` is low, `rd_data_o` is 0 and the captured write enable is cleared. The lane-enable capture register has no reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the read register and the captured write enable |
| ce_i | input | 1 | Clock enable; gates both stages |
| we_i | input | 1 | Write request |
| be_i | input | NUM_LANES (4) | Lane enables; bit k selects lane k |
| addr_i | input | ADDR_W (6) | Word address |
| wdata_i | input | DATA_W (36) | Write data |
| rd_data_o | output | DATA_W (36) | Registered read data |

## Verification
The 36-bit memory is first filled with full-word writes and then read back. This confirms the two-edge latency and that every address holds its own word. A series of lane masks is then applied to one address: single lanes, alternating lanes, a middle pair, all ones and all zeros. Each mask is followed by a read. Any error in lane position, lane size or retention of the other lanes shows up as a mismatch against a model built from 9-bit lanes. Separate patterns test the remaining behaviour: writes with the write enable low, a write followed at once by a read of the same address (old data from the write access, new data from the read), and a stall with write inputs active. A 16-bit instance checks the 8-bit mapping, and an 8-bit instance with masking off shows that the enable input is ignored.

// File: rtl/blr_pkg.sv
package blr_pkg;

  // Lane size for a given word width: 9-bit groups when the width is a
  // multiple of nine, 8-bit groups otherwise; one full-width lane when
  // masking is off.
  function automatic int lane_width(int dw, bit use_be);
    if (!use_be) return dw;
    return ((dw % 9) == 0) ? 9 : 8;
  endfunction

  function automatic int lane_count(int dw, bit use_be);
    return dw / lane_width(dw, use_be);
  endfunction

  function automatic bit width_is_legal(int dw, bit use_be);
    if (!use_be) return 1'b1;
    return (dw == 16) || (dw == 18) || (dw == 32) || (dw == 36);
  endfunction

endpackage

// File: rtl/blr_capture.sv
module blr_capture #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 36,
  parameter int NUM_LANES = 4,
  parameter bit USE_BE    = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_i,
  input  logic                 we_i,
  input  logic [NUM_LANES-1:0] be_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 we_q,
  output logic [NUM_LANES-1:0] be_q,
  output logic [ADDR_W-1:0]    addr_q,
  output logic [DATA_W-1:0]    wdata_q
);

  // Only the write flag is cleared, so no stale request can fire after reset.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   we_q <= 1'b0;
    else if (ce_i) we_q <= we_i;
  end

  always_ff @(posedge clk_i) begin
    if (ce_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  generate
    if (USE_BE) begin : g_be_reg
      // Lane-enable register: enabled capture, deliberately without a clear.
      always_ff @(posedge clk_i) begin
        if (ce_i) be_q <= be_i;
      end
    end else begin : g_be_tied
      logic unused_be;
      assign unused_be = ^be_i;
      assign be_q      = '1;
    end
  endgenerate

endmodule

// File: rtl/blr_lane.sv
module blr_lane #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] wd_i,
  output logic [LANE_W-1:0] rd_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] store [DEPTH];

  always_ff @(posedge clk_i) begin
    if (ce_i && wr_i) store[addr_i] <= wd_i;
  end

  // Non-blocking update: a same-address write is not yet visible here.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_o <= '0;
    else if (ce_i) rd_o <= store[addr_i];
  end

endmodule

// File: rtl/byte_lane_ram.sv
module byte_lane_ram #(
  parameter int  ADDR_W    = 6,
  parameter int  DATA_W    = 36,
  parameter bit  USE_BE    = 1'b1,
  localparam int LANE_W    = blr_pkg::lane_width(DATA_W, USE_BE),
  localparam int NUM_LANES = blr_pkg::lane_count(DATA_W, USE_BE)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_i,
  input  logic                 we_i,
  input  logic [NUM_LANES-1:0] be_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rd_data_o
);

  generate
    if (!blr_pkg::width_is_legal(DATA_W, USE_BE)) begin : g_bad_cfg
      $error("byte_lane_ram: lane masking needs a word of 16, 18, 32 or 36 bits");
    end
  endgenerate

  logic                 we_q;
  logic [NUM_LANES-1:0] be_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q;

  blr_capture #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_LANES(NUM_LANES),
    .USE_BE   (USE_BE)
  ) u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (ce_i),
    .we_i   (we_i),
    .be_i   (be_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .we_q   (we_q),
    .be_q   (be_q),
    .addr_q (addr_q),
    .wdata_q(wdata_q)
  );

  generate
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic lane_wr;
      assign lane_wr = we_q & be_q[l];

      blr_lane #(
        .ADDR_W(ADDR_W),
        .LANE_W(LANE_W)
      ) u_lane (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ce_i  (ce_i),
        .wr_i  (lane_wr),
        .addr_i(addr_q),
        .wd_i  (wdata_q[l*LANE_W +: LANE_W]),
        .rd_o  (rd_data_o[l*LANE_W +: LANE_W])
      );
    end
  endgenerate

endmodule

// File: rtl/blr_chk.sv
module blr_chk #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 36,
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 9
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ce_i,
  input logic [DATA_W-1:0]    rd_data_o,
  input logic                 we_q,
  input logic [NUM_LANES-1:0] be_q,
  input logic [ADDR_W-1:0]    addr_q,
  input logic [DATA_W-1:0]    wdata_q
);

  logic [DATA_W-1:0] cur_mask;
  generate
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_mask
      assign cur_mask[l*LANE_W +: LANE_W] = {LANE_W{we_q & be_q[l]}};
    end
  endgenerate

  // Remembers the previous executed access so a follow-up to the same word
  // can be predicted from its read result and its write lanes.
  logic              prev_valid;
  logic [ADDR_W-1:0] prev_addr;
  logic [DATA_W-1:0] prev_data;
  logic [DATA_W-1:0] prev_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_valid <= 1'b0;
      prev_addr  <= '0;
      prev_data  <= '0;
      prev_mask  <= '0;
    end else if (ce_i) begin
      prev_valid <= 1'b1;
      prev_addr  <= addr_q;
      prev_data  <= wdata_q;
      prev_mask  <= cur_mask;
    end
  end

  logic same_word;
  assign same_word = ce_i && prev_valid && (addr_q == prev_addr);

  // R3 / R1 / R7: a repeat access sees written lanes new, all others as before
  assert_lane_merge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    same_word |=> rd_data_o == (($past(prev_data) & $past(prev_mask)) |
                                ($past(rd_data_o) & ~$past(prev_mask))));

  assert_stall_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(rd_data_o));

  assert_stall_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> ($stable(addr_q) && $stable(wdata_q) && $stable(be_q) && $stable(we_q)));

  assert_reset_out_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (rd_data_o == '0 && !we_q));

endmodule

bind byte_lane_ram blr_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_LANES(NUM_LANES),
  .LANE_W   (LANE_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_i     (ce_i),
  .rd_data_o(rd_data_o),
  .we_q     (we_q),
  .be_q     (be_q),
  .addr_q   (addr_q),
  .wdata_q  (wdata_q)
);

// File: tb/byte_lane_ram_tb.sv
`timescale 1ns/1ps
module byte_lane_ram_tb;

  localparam int AW = 6;
  localparam int DW = 36;
  localparam int NL = 4;
  localparam int LW = 9;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          ce, we;
  logic [NL-1:0] be;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;

  byte_lane_ram #(.ADDR_W(AW), .DATA_W(DW), .USE_BE(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .we_i(we), .be_i(be),
    .addr_i(addr), .wdata_i(wdata), .rd_data_o(rdata));

  logic        s_we;
  logic [1:0]  s_be;
  logic [3:0]  s_addr;
  logic [15:0] s_wd, s_rd;
  byte_lane_ram #(.ADDR_W(4), .DATA_W(16), .USE_BE(1'b1)) u_dut16 (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(1'b1), .we_i(s_we), .be_i(s_be),
    .addr_i(s_addr), .wdata_i(s_wd), .rd_data_o(s_rd));

  logic       n_we;
  logic [0:0] n_be;
  logic [3:0] n_addr;
  logic [7:0] n_wd, n_rd;
  byte_lane_ram #(.ADDR_W(4), .DATA_W(8), .USE_BE(1'b0)) u_dut8 (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(1'b1), .we_i(n_we), .be_i(n_be),
    .addr_i(n_addr), .wdata_i(n_wd), .rd_data_o(n_rd));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [DW-1:0] exp;
    bit            chk;
    string         tag;
  } item_t;
  item_t sbq[$];

  logic [DW-1:0] model [1 << AW];

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Driver: one access per cycle, expected read pushed before the model update.
  task automatic op(bit w, logic [NL-1:0] b, logic [AW-1:0] a,
                    logic [DW-1:0] d, bit chk, string tag);
    item_t it;
    @(negedge clk);
    ce = 1'b1; we = w; be = b; addr = a; wdata = d;
    it.exp = model[a]; it.chk = chk; it.tag = tag;
    sbq.push_back(it);
    if (w) for (int l = 0; l < NL; l++)
      if (b[l]) model[a][l*LW +: LW] = d[l*LW +: LW];
  endtask

  task automatic stall(int n, logic [AW-1:0] a);
    logic [DW-1:0] hold;
    @(negedge clk);
    hold = rdata;
    ce = 1'b0; we = 1'b1; be = '1; addr = a; wdata = ~model[a];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R5 read output held during stall", rdata, hold);
    end
  endtask

  // Monitor: a result is due after an enabled edge once stage one held a request.
  logic stage1, due;
  always @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      due    <= 1'b0;
    end else begin
      due <= ce && stage1;
      if (ce) stage1 <= 1'b1;
    end
  end

  always @(negedge clk) begin : monitor
    item_t it;
    if (due && !done) begin
      if (sbq.size() == 0) begin
        check("R6 unexpected result", rdata, 'x);
      end else begin
        it = sbq.pop_front();
        if (it.chk) check(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic w16(bit w, logic [1:0] b, logic [3:0] a, logic [15:0] d);
    @(negedge clk); s_we = w; s_be = b; s_addr = a; s_wd = d;
  endtask
  task automatic r16(logic [3:0] a, logic [15:0] exp, string tag);
    @(negedge clk); s_we = 1'b0; s_addr = a;
    @(negedge clk); @(negedge clk);
    check(tag, DW'(s_rd), DW'(exp));
  endtask
  task automatic w8(bit w, logic [0:0] b, logic [3:0] a, logic [7:0] d);
    @(negedge clk); n_we = w; n_be = b; n_addr = a; n_wd = d;
  endtask
  task automatic r8(logic [3:0] a, logic [7:0] exp, string tag);
    @(negedge clk); n_we = 1'b0; n_addr = a;
    @(negedge clk); @(negedge clk);
    check(tag, DW'(n_rd), DW'(exp));
  endtask

  function automatic logic [DW-1:0] pat(int a);
    return {4{9'(a * 37 + 5)}};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL R6 watchdog act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stimulus
    logic [NL-1:0] masks [7];
    rst_n = 1'b0; ce = 1'b0; we = 1'b0; be = '0; addr = '0; wdata = '0;
    s_we = 1'b0; s_be = '0; s_addr = '0; s_wd = '0;
    n_we = 1'b0; n_be = '0; n_addr = '0; n_wd = '0;
    repeat (3) @(negedge clk);
    check("R9 read data zero in reset", rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 read data zero after reset", rdata, '0);

    for (int a = 0; a < (1 << AW); a++) op(1'b1, '1, AW'(a), pat(a), 1'b0, "init");
    for (int a = 0; a < (1 << AW); a++) op(1'b0, '0, AW'(a), '0, 1'b1, "R6 readback latency");

    op(1'b1, 4'b0001, 6'd5, 36'h9_8765_4321, 1'b1, "R7 old data on same-address write");
    op(1'b0, 4'b0000, 6'd5, '0, 1'b1, "R2 lane 0 is bits 8:0");

    masks = '{4'b0010, 4'b0100, 4'b1000, 4'b0101, 4'b1010, 4'b0110, 4'b1111};
    foreach (masks[i]) begin
      op(1'b1, masks[i], 6'd7, {$urandom, $urandom}, 1'b1, "R7 old data on write");
      op(1'b0, '0, 6'd7, '0, 1'b1, "R2 R3 masked lanes kept");
    end

    op(1'b1, 4'b0000, 6'd9, 36'hF_FFFF_FFFF, 1'b1, "R3 zero-mask write");
    op(1'b0, '0, 6'd9, '0, 1'b1, "R3 zero mask leaves word");

    op(1'b0, 4'b1111, 6'd11, 36'h0_0000_0000, 1'b1, "R1 read with enables set");
    op(1'b0, '0, 6'd11, '0, 1'b1, "R1 no write without write enable");

    op(1'b1, '1, 6'd13, 36'hA_5A5A_5A5A, 1'b1, "R7 old data before full write");
    op(1'b0, '0, 6'd13, '0, 1'b1, "R6 read right after write");

    stall(3, 6'd14);
    op(1'b0, '0, 6'd14, '0, 1'b1, "R5 no write while ce low");
    op(1'b0, '0, 6'd13, '0, 1'b1, "R5 pipeline resumes");
    op(1'b0, '0, 6'd0,  '0, 1'b1, "R6 trailing read");
    op(1'b0, '0, 6'd1,  '0, 1'b1, "R6 trailing read");
    @(negedge clk);
    ce = 1'b0; we = 1'b0;
    repeat (2) @(negedge clk);

    w16(1'b1, 2'b11, 4'd3, 16'hAAAA);
    w16(1'b1, 2'b01, 4'd3, 16'h1234);
    r16(4'd3, 16'hAA34, "R4 enable bit 0 covers 7:0");
    w16(1'b1, 2'b10, 4'd3, 16'h5678);
    r16(4'd3, 16'h5634, "R4 enable bit 1 covers 15:8");

    w8(1'b1, 1'b0, 4'd2, 8'h5A);
    r8(4'd2, 8'h5A, "R8 lane enable ignored when masking off");
    w8(1'b0, 1'b1, 4'd2, 8'h11);
    r8(4'd2, 8'h5A, "R8 write enable alone gates narrow write");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule